// File: doc/BRIEF.md
# Receive Character FIFO with Mode-Selectable Flag Polarity

This block buffers received 14-bit characters between a receive control engine and a host-side read port. Characters from the engine are pushed on the write side. A host or external state machine drains them through a FIFO-style port in the same clock domain. The block holds up to 256 characters. It reports empty, full and half-full status from registers, so a Moore-type controller can act on the flags directly.

A static mode strap selects one of two timing models. In the low-true model, the empty flag, the full flag and the read enable are all active low. In the high-true model, all three are active high. The half-full flag is active low in both models.

Reading takes two steps. The host first addresses the device with an active-low select. It then asserts the read enable in the next cycle. Output drivers for the flags and the data bus are modelled as enable outputs. The flag drivers follow the sampled select. The data drivers are on only for a cycle in which a read cycle ran.

Top module: `rx_fifo_port`

## Requirements
- R1: Characters leave in the order they were written. Up to 256 characters of 14 bits are held.
- R2: With `mode_i`=0, `empty_o`, `full_o` and `rd_en_i` are active low (0 = asserted).
- R3: With `mode_i`=1, `empty_o`, `full_o` and `rd_en_i` are active high (1 = asserted).
- R4: `half_no` is 0 exactly when the occupancy is 128 or more, in either mode.
- R5: The flags are registered. After the clock edge at which a write or read is accepted, they show the new occupancy.
- R6: `flag_oe_o` is 1 in the cycle after `sel_ni` was sampled 0, and 0 in the cycle after `sel_ni` was sampled 1.
- R7: A read cycle starts only if the read enable is sampled active at the edge right after an edge that sampled `sel_ni`=0. For that one cycle, `rd_data_oe_o` is 1 and `rd_data_o` carries the oldest character.
- R8: A read of an empty FIFO leaves the occupancy unchanged, and so does a write to a full FIFO. A write beyond 256 entries is dropped.
- R9: `rd_data_o` keeps its previous value whenever no character is popped.
- R10: While `rst_ni` is 0, the occupancy is 0 and both enable outputs are 0. The flags show the empty state in the polarity of the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Timing model strap: 0 low-true, 1 high-true |
| wr_valid_i | input | 1 | Write strobe from the receive engine |
| wr_data_i | input | 14 | Character to store |
| sel_ni | input | 1 | Device select, active low |
| rd_en_i | input | 1 | Read enable, polarity set by `mode_i` |
| rd_data_o | output | 14 | Registered read data |
| rd_data_oe_o | output | 1 | Data bus driver enable |
| empty_o | output | 1 | Empty flag, polarity set by `mode_i` |
| full_o | output | 1 | Full flag, polarity set by `mode_i` |
| half_no | output | 1 | Half-full flag, always active low |
| flag_oe_o | output | 1 | Flag driver enable |

## Verification
A write sampled at edge N shows on the flags when the bench samples after edge N. The flag driver enable likewise follows the select sampled at that same edge. For data, the select must be low at edge N and the read enable active at edge N+1; the character and the data enable then appear after edge N+1. The bench drives inputs on the falling edge. Its model advances at each rising edge, and it compares every output at the next falling edge, so each expectation is checked in the cycle it is due.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
  } rxf_flags_t;

  localparam rxf_flags_t FLAGS_RST = '{empty: 1'b1, full: 1'b0, half: 1'b0};
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 14,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // output register holds unless a pop occurs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_req_i,
  input  logic          pop_req_i,
  output logic          push_o,
  output logic          pop_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] occ_o,
  output rxf_flags_t    flags_o
);
  logic [CW-1:0] occ_nxt;

  // gate on registered state; illegal requests leave everything unchanged
  assign push_o  = push_req_i & ~flags_o.full;
  assign pop_o   = pop_req_i & ~flags_o.empty;
  assign occ_nxt = occ_o + CW'(push_o) - CW'(pop_o);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o  <= '0;
      rptr_o  <= '0;
      occ_o   <= '0;
      flags_o <= FLAGS_RST;
    end else begin
      if (push_o) wptr_o <= ptr_inc(wptr_o);
      if (pop_o)  rptr_o <= ptr_inc(rptr_o);
      occ_o         <= occ_nxt;
      flags_o.empty <= (occ_nxt == '0);
      flags_o.full  <= (occ_nxt == CW'(DEPTH));
      flags_o.half  <= (occ_nxt >= CW'(HALF));
    end
  end
endmodule

// File: rtl/rxf_port.sv
module rxf_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic rd_act_i,
  output logic read_go_o,
  output logic flag_oe_o,
  output logic data_oe_o
);
  logic sel_q;

  // read needs select sampled low on the previous edge
  assign read_go_o = rd_act_i & sel_q;
  assign flag_oe_o = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      data_oe_o <= 1'b0;
    end else begin
      sel_q     <= ~sel_ni;
      data_oe_o <= read_go_o;
    end
  end
endmodule

// File: rtl/rx_fifo_port.sv
module rx_fifo_port
  import rxf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 14,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             wr_valid_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             sel_ni,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_data_oe_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             half_no,
  output logic             flag_oe_o
);
  logic          rd_act, read_go, push, pop;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ;
  rxf_flags_t    flags;

  // mode_i is a static strap; polarity applied after the flag registers
  assign rd_act  = mode_i ? rd_en_i : ~rd_en_i;
  assign empty_o = mode_i ? flags.empty : ~flags.empty;
  assign full_o  = mode_i ? flags.full : ~flags.full;
  assign half_no = ~flags.half;

  rxf_port u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_ni    (sel_ni),
    .rd_act_i  (rd_act),
    .read_go_o (read_go),
    .flag_oe_o (flag_oe_o),
    .data_oe_o (rd_data_oe_o)
  );

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_req_i (wr_valid_i),
    .pop_req_i  (read_go),
    .push_o     (push),
    .pop_o      (pop),
    .wptr_o     (wptr),
    .rptr_o     (rptr),
    .occ_o      (occ),
    .flags_o    (flags)
  );

  rxf_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push),
    .waddr_i (wptr),
    .wdata_i (wr_data_i),
    .re_i    (pop),
    .raddr_i (rptr),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/rx_fifo_port_chk.sv
module rx_fifo_port_chk #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 14,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             sel_ni,
  input logic             rd_en_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             rd_data_oe_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             half_no,
  input logic             flag_oe_o,
  input logic [CW-1:0]    occ
);
  logic rd_act;
  assign rd_act = mode_i ? rd_en_i : ~rd_en_i;

  // R6
  sel_flag_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ni |=> flag_oe_o);
  // R6
  desel_flag_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> !flag_oe_o);
  // R7
  read_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni ##1 rd_act) |=> rd_data_oe_o);
  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_oe_o |-> $stable(rd_data_o));
  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CW'(DEPTH));
  // R4
  half_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_no == (occ < CW'(DEPTH / 2)));
  // R2
  full_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o == mode_i) == (occ == CW'(DEPTH)));
  // R3
  empty_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o == mode_i) == (occ == '0));
endmodule

bind rx_fifo_port rx_fifo_port_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/rx_fifo_port_bench.sv
`timescale 1ns/1ps
module rx_fifo_port_bench;
  localparam int DEPTH = 256;
  localparam int WIDTH = 14;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             mode_i = 1'b0;
  logic             wr_valid_i = 1'b0;
  logic [WIDTH-1:0] wr_data_i = '0;
  logic             sel_ni = 1'b1;
  logic             rd_en_i = 1'b1;
  logic [WIDTH-1:0] rd_data_o;
  logic             rd_data_oe_o, empty_o, full_o, half_no, flag_oe_o;

  rx_fifo_port u_rx_fifo_port (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 0;

  // scoreboard model
  logic [WIDTH-1:0] sb_q[$];
  int               m_occ;
  bit               m_selq, m_doe, m_popped;
  logic [WIDTH-1:0] m_data;
  int               pops;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic monitor();
    bit e = (m_occ == 0), f = (m_occ == DEPTH);
    chk(mode_i ? "R3 empty" : "R2 empty", empty_o, mode_i ? e : !e);
    chk(mode_i ? "R3 full" : "R2 full", full_o, mode_i ? f : !f);
    chk("R4 half", half_no, !(m_occ >= DEPTH / 2));
    chk("R6 flag_oe", flag_oe_o, m_selq);
    chk("R7 data_oe", rd_data_oe_o, m_doe);
    chk(m_popped ? "R1 order" : "R9 hold", rd_data_o, m_data);
  endtask

  // driver: one cycle; rd is the logical read request
  task automatic cyc(input bit wr, input logic [WIDTH-1:0] d, input bit sel_n, input bit rd);
    bit go, pop, push;
    wr_valid_i = wr;
    wr_data_i  = d;
    sel_ni     = sel_n;
    rd_en_i    = mode_i ? rd : !rd;
    @(posedge clk_i);
    go   = rd && m_selq;
    pop  = go && (m_occ > 0);
    push = wr && (m_occ < DEPTH);
    m_doe = go;
    m_popped = pop;
    if (pop) begin m_data = sb_q.pop_front(); pops++; end
    if (push) sb_q.push_back(d);
    m_occ = m_occ + int'(push) - int'(pop);
    m_selq = !sel_n;
    @(negedge clk_i);
    monitor();
  endtask

  task automatic run_mode(input bit md);
    mode_i = md;
    rst_ni = 1'b0;
    sb_q.delete();
    m_occ = 0; m_selq = 0; m_doe = 0; m_popped = 0; m_data = '0;
    repeat (3) @(negedge clk_i);
    // R10 reset state in current mode polarity
    chk("R10 empty", empty_o, md);
    chk("R10 full", full_o, !md);
    chk("R10 half", half_no, 1'b1);
    chk("R10 oe", {flag_oe_o, rd_data_oe_o}, 2'b00);
    rst_ni = 1'b1;
    cyc(0, '0, 1, 0);
    // R5 single write updates flags at the same edge
    cyc(1, 14'h1A5, 1, 0);
    chk("R5 not empty", empty_o, !md);
    // read enable without prior select: no read cycle
    cyc(0, '0, 1, 1);
    chk("R7 no select", rd_data_oe_o, 1'b0);
    // select then read
    cyc(0, '0, 0, 0);
    cyc(0, '0, 1, 1);
    chk("R7 popped", rd_data_o, 14'h1A5);
    // fill past capacity
    for (int i = 0; i < DEPTH + 4; i++) cyc(1, WIDTH'(i * 37 + md * 5), 1, 0);
    chk("R8 full held", full_o, md);
    // drain with select held and read active
    pops = 0;
    cyc(0, '0, 0, 0);
    for (int i = 0; i < DEPTH + 3; i++) cyc(0, '0, 0, 1);
    chk("R8 pop count", pops, DEPTH);
    chk("R8 empty after drain", empty_o, md);
    // empty read keeps data
    cyc(0, '0, 0, 1);
    chk("R9 empty read", rd_data_o, WIDTH'((DEPTH - 1) * 37 + md * 5));
    cyc(0, '0, 1, 0);
  endtask

  initial begin
    @(negedge clk_i);
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule